// File: doc/BRIEF.md
# Interleaved Request Parity Guard

This block protects the address phase of an AHB-style request against transient bit flips on the wires between a manager and a subordinate. On the manager side it computes six even-parity bits from the request: four cover the address with the bits taken four apart, one covers the control fields, and one covers the transfer type. The same generator runs on the subordinate side and compares its result with the parity bits that arrived with the request.

Parity is checked only on an accepted, active transfer. When a covered group disagrees, the block drives the standard two-cycle AHB error response. The subordinate merges this response with its own. A parameter picks the instruction-bus variant, where the control group is empty, or the data-bus variant, where the control group covers three bits.

Top module: `ahbp_guard`

## Requirements
- R1: Bit k of `gen_par` (k = 0..3) is the XOR of `haddr` bits k, k+4, k+8, ... up to bit 28+k.
- R2: In the data-bus variant, `gen_par[4]` is the XOR of `hwrite`, `hsize[1]` and `hsize[0]`. In the instruction-bus variant, `gen_par[4]` is always 0.
- R3: In both variants, `gen_par[5]` equals `htrans[1]`.
- R4: A request is checked only in a cycle where `hready_in` is 1 and `htrans[1]` is 1 (NONSEQ = 2'b10, SEQ = 2'b11). IDLE (2'b00), BUSY (2'b01), or `hready_in` at 0 never starts an error response, whatever `par_in` holds.
- R5: If a checked request has a mismatch between `par_in` and `gen_par` in any covered bit, the next cycle shows `resp_err`=1 with `resp_ready`=0. The cycle after that shows `resp_err`=1 with `resp_ready`=1. After that the outputs return to `resp_err`=0 and `resp_ready`=1.
- R6: In the instruction-bus variant, `par_in[4]` is ignored, so a value of 1 there never causes an error.
- R7: While reset is asserted and in the first cycle after it is released, `resp_err`=0 and `resp_ready`=1.
- R8: A mismatched request that is checked during the second error cycle starts a new two-cycle error response right away.
- R9: A checked request whose parity matches leaves `resp_err`=0 and `resp_ready`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | 32 | Request address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write flag |
| hsize | input | 3 | Transfer size |
| hready_in | input | 1 | Bus ready; marks the cycle in which the request is accepted |
| par_in | input | 6 | Parity bits received with the request |
| gen_par | output | 6 | Parity bits computed from the request signals |
| resp_err | output | 1 | Error response from the parity guard |
| resp_ready | output | 1 | Ready contribution from the parity guard |

## Verification
The bench walks a single one through every address bit and also drives mixed address patterns. A wrong lane stride or a shifted lane would then show up as a flipped parity bit. The control and transfer groups are swept over every combination of `hsize`, `hwrite` and `htrans` in both variants. This exposes a design that folds `hsize[2]` or `htrans[0]` into a group, or that leaves the instruction-variant control bit non-zero.

Each parity bit is corrupted in turn, and the bench checks both cycles of the error response. A design that drops the low-ready cycle, or holds the error for only one cycle, fails these checks. Bad parity is also sent with IDLE, with BUSY, and with ready low. Here a guard that checks too eagerly would raise a false error. A design that ignored a new request during the second error cycle, or that compared the unused control bit, would also be caught.

// File: rtl/ahbp_pkg.sv
package ahbp_pkg;
  typedef enum logic {BUS_INSTR = 1'b0, BUS_DATA = 1'b1} bus_kind_e;
  typedef enum logic [1:0] {RS_OK = 2'd0, RS_ERR_WAIT = 2'd1, RS_ERR_DONE = 2'd2} resp_state_e;
endpackage

// File: rtl/ahbp_par_gen.sv
module ahbp_par_gen
  import ahbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 4,
  parameter bus_kind_e BUS = BUS_DATA,
  localparam int PAR_W = LANES + 2
) (
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  output logic [PAR_W-1:0]  par
);
  localparam int PER_LANE = ADDR_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [PER_LANE-1:0] lane_bits;
    for (genvar j = 0; j < PER_LANE; j++) begin : g_pick
      assign lane_bits[j] = haddr[j*LANES + g];
    end
    assign par[g] = ^lane_bits;
  end

  if (BUS == BUS_DATA) begin : g_ctl_data
    logic unused_ctl;
    assign par[LANES] = hwrite ^ hsize[1] ^ hsize[0];
    assign unused_ctl = hsize[2];
  end else begin : g_ctl_instr
    logic unused_ctl;
    assign par[LANES] = 1'b0;
    assign unused_ctl = ^{hwrite, hsize};
  end

  logic unused_trans;
  assign par[LANES+1] = htrans[1];
  assign unused_trans = htrans[0];
endmodule

// File: rtl/ahbp_par_cmp.sv
module ahbp_par_cmp
  import ahbp_pkg::*;
#(
  parameter int LANES = 4,
  parameter bus_kind_e BUS = BUS_DATA,
  localparam int PAR_W = LANES + 2
) (
  input  logic [PAR_W-1:0] expect_par,
  input  logic [PAR_W-1:0] rcv_par,
  output logic             mismatch
);
  localparam logic [PAR_W-1:0] COVER =
    (BUS == BUS_DATA) ? {PAR_W{1'b1}} : ~(PAR_W'(1) << LANES);

  always_comb begin
    mismatch = |((expect_par ^ rcv_par) & COVER);
  end
endmodule

// File: rtl/ahbp_err_resp.sv
module ahbp_err_resp
  import ahbp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic check_en,
  input  logic mismatch,
  output logic resp_err,
  output logic resp_ready
);
  resp_state_e state_q, state_d;
  logic        state_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RS_OK:       if (check_en && mismatch) state_d = RS_ERR_WAIT;
      RS_ERR_WAIT: state_d = RS_ERR_DONE;
      RS_ERR_DONE: state_d = (check_en && mismatch) ? RS_ERR_WAIT : RS_OK;
      default:     state_d = RS_OK;
    endcase
    state_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_OK;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    resp_err   = (state_q != RS_OK);
    resp_ready = (state_q != RS_ERR_WAIT);
  end
endmodule

// File: rtl/ahbp_guard.sv
module ahbp_guard
  import ahbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES = 4,
  parameter bus_kind_e BUS = BUS_DATA,
  localparam int PAR_W = LANES + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic              hready_in,
  input  logic [PAR_W-1:0]  par_in,
  output logic [PAR_W-1:0]  gen_par,
  output logic              resp_err,
  output logic              resp_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       mismatch;
  logic       check_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  ahbp_par_gen #(.ADDR_W(ADDR_W), .LANES(LANES), .BUS(BUS)) u_gen (
    .haddr (haddr),
    .htrans(htrans),
    .hwrite(hwrite),
    .hsize (hsize),
    .par   (gen_par)
  );

  ahbp_par_cmp #(.LANES(LANES), .BUS(BUS)) u_cmp (
    .expect_par(gen_par),
    .rcv_par   (par_in),
    .mismatch  (mismatch)
  );

  assign check_en = hready_in & htrans[1];

  ahbp_err_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .check_en  (check_en),
    .mismatch  (mismatch),
    .resp_err  (resp_err),
    .resp_ready(resp_ready)
  );
endmodule

// File: rtl/ahbp_guard_chk.sv
module ahbp_guard_chk #(
  parameter int LANES = 4,
  localparam int PAR_W = LANES + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       htrans,
  input logic             hready_in,
  input logic [PAR_W-1:0] par_in,
  input logic [PAR_W-1:0] gen_par,
  input logic             resp_err,
  input logic             resp_ready
);
  logic started_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  AST_ERR_SECOND_CYCLE: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (resp_err && !resp_ready) |=> (resp_err && resp_ready)); // R5

  AST_ADDR_MISMATCH_RESP: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (hready_in && htrans[1] && (par_in[LANES-1:0] != gen_par[LANES-1:0]))
      |=> (resp_err && !resp_ready)); // R5

  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (!rst_n || !started_q)
    (!(hready_in && htrans[1]) && !(resp_err && !resp_ready))
      |=> !(resp_err && !resp_ready)); // R4

  AST_READY_WHEN_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_err |-> resp_ready); // R9
endmodule

bind ahbp_guard ahbp_guard_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/sim_ahbp_guard.sv
module sim_ahbp_guard;
  import ahbp_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic        hready_in;
  logic [5:0]  par_in0, par_in1;
  logic [5:0]  gen_par0, gen_par1;
  logic        resp_err0, resp_ready0, resp_err1, resp_ready1;
  int          checks = 0;
  int          failures = 0;
  bit          done = 0;

  ahbp_guard #(.BUS(BUS_DATA)) u0 (
    .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hready_in(hready_in), .par_in(par_in0), .gen_par(gen_par0),
    .resp_err(resp_err0), .resp_ready(resp_ready0));

  ahbp_guard #(.BUS(BUS_INSTR)) u1 (
    .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hready_in(hready_in), .par_in(par_in1), .gen_par(gen_par1),
    .resp_err(resp_err1), .resp_ready(resp_ready1));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] model_par(input logic [31:0] a, input logic [1:0] t,
                                           input logic w, input logic [2:0] s, input bit is_data);
    logic [5:0] p = '0;
    for (int b = 0; b < 32; b++) p[b % 4] = p[b % 4] ^ a[b];
    p[4] = is_data ? (w ^ s[1] ^ s[0]) : 1'b0;
    p[5] = t[1];
    return p;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_resp(input string req, input logic [1:0] exp0, input logic [1:0] exp1);
    check(req, {6'd0, resp_err0, resp_ready0}, {6'd0, exp0});
    check(req, {6'd0, resp_err1, resp_ready1}, {6'd0, exp1});
  endtask

  task automatic apply(input logic [31:0] a, input logic [1:0] t, input logic w,
                       input logic [2:0] s, input logic rdy,
                       input logic [5:0] flip0, input logic [5:0] flip1);
    haddr = a; htrans = t; hwrite = w; hsize = s; hready_in = rdy;
    par_in0 = model_par(a, t, w, s, 1'b1) ^ flip0;
    par_in1 = model_par(a, t, w, s, 1'b0) ^ flip1;
  endtask

  task automatic go_idle();
    apply(32'h0, 2'b00, 1'b0, 3'd0, 1'b1, 6'd0, 6'd0);
  endtask

  task automatic run_seq(input string req, input logic [31:0] a, input logic [1:0] t,
                         input logic rdy, input logic [5:0] f0, input logic [5:0] f1,
                         input bit e0, input bit e1);
    apply(a, t, 1'b1, 3'd2, rdy, f0, f1);
    @(negedge clk);
    go_idle();
    check_resp(req, e0 ? 2'b10 : 2'b01, e1 ? 2'b10 : 2'b01);
    @(negedge clk);
    check_resp(req, e0 ? 2'b11 : 2'b01, e1 ? 2'b11 : 2'b01);
    @(negedge clk);
    check_resp(req, 2'b01, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(32'h0, 2'b00, 1'b0, 3'd0, 1'b0, 6'd0, 6'd0);
    repeat (3) @(negedge clk);
    check_resp("R7 in reset", 2'b01, 2'b01);
    rst_n = 1'b1;
    @(negedge clk);
    check_resp("R7 after release", 2'b01, 2'b01);
    repeat (3) @(negedge clk);

    // R1: walking one and mixed address patterns
    for (int i = 0; i < 48; i++) begin
      logic [31:0] a;
      a = (i < 32) ? (32'h1 << i) : (32'(i) * 32'h9E3779B9) ^ 32'hA5C3_0F1E;
      apply(a, 2'b00, 1'b0, 3'd0, 1'b0, 6'd0, 6'd0);
      #1;
      check("R1 data lanes", {4'd0, gen_par0[3:0]}, {4'd0, model_par(a, 2'b00, 1'b0, 3'd0, 1'b1)}[3:0]);
      check("R1 instr lanes", {4'd0, gen_par1[3:0]}, {4'd0, model_par(a, 2'b00, 1'b0, 3'd0, 1'b0)}[3:0]);
      @(negedge clk);
    end

    // R2, R3: control and transfer groups, all combinations
    for (int c = 0; c < 64; c++) begin
      logic [1:0] t;
      logic       w;
      logic [2:0] s;
      logic [5:0] m0, m1;
      {t, w, s} = 6'(c);
      apply(32'h1234_5678, t, w, s, 1'b0, 6'd0, 6'd0);
      m0 = model_par(32'h1234_5678, t, w, s, 1'b1);
      m1 = model_par(32'h1234_5678, t, w, s, 1'b0);
      #1;
      check("R2 data ctl", {7'd0, gen_par0[4]}, {7'd0, m0[4]});
      check("R2 instr ctl", {7'd0, gen_par1[4]}, {7'd0, m1[4]});
      check("R3 data trans", {7'd0, gen_par0[5]}, {7'd0, m0[5]});
      check("R3 instr trans", {7'd0, gen_par1[5]}, {7'd0, m1[5]});
      @(negedge clk);
      check_resp("R4 ready low sweep", 2'b01, 2'b01);
    end
    go_idle();
    @(negedge clk);

    // R9: good NONSEQ and SEQ transfers
    run_seq("R9 good nonseq", 32'hDEAD_BEEF, 2'b10, 1'b1, 6'd0, 6'd0, 1'b0, 1'b0);
    run_seq("R9 good seq", 32'h0F0F_1234, 2'b11, 1'b1, 6'd0, 6'd0, 1'b0, 1'b0);

    // R5, R6: corrupt each group in turn
    for (int b = 0; b < 6; b++) begin
      logic [5:0] f;
      f = 6'(1) << b;
      run_seq(b == 4 ? "R6 instr ctl ignored / R5 data" : "R5 group error",
              32'h8000_0011 + 32'(b), 2'b10, 1'b1, f, f, 1'b1, b != 4);
    end

    // R4: bad parity with IDLE, BUSY, and ready low
    run_seq("R4 idle ignored", 32'h0000_00F1, 2'b00, 1'b1, 6'h3F, 6'h3F, 1'b0, 1'b0);
    run_seq("R4 busy ignored", 32'h0000_00F1, 2'b01, 1'b1, 6'h0F, 6'h0F, 1'b0, 1'b0);
    run_seq("R4 ready low ignored", 32'h0000_00F1, 2'b10, 1'b0, 6'h0F, 6'h0F, 1'b0, 1'b0);

    // R8: new mismatch in second error cycle restarts response
    apply(32'h4444_0000, 2'b10, 1'b0, 3'd0, 1'b1, 6'h01, 6'h01);
    @(negedge clk);
    apply(32'h0, 2'b00, 1'b0, 3'd0, 1'b0, 6'd0, 6'd0);
    check_resp("R8 first wait", 2'b10, 2'b10);
    @(negedge clk);
    check_resp("R8 first done", 2'b11, 2'b11);
    apply(32'h4444_0004, 2'b11, 1'b0, 3'd0, 1'b1, 6'h02, 6'h02);
    @(negedge clk);
    go_idle();
    check_resp("R8 restart wait", 2'b10, 2'b10);
    @(negedge clk);
    check_resp("R8 restart done", 2'b11, 2'b11);
    @(negedge clk);
    check_resp("R8 back to ok", 2'b01, 2'b01);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule